// File: doc/BRIEF.md
# Flexible Power Sequencer Controller

This block drives the enable and low-power controls of a set of power outputs: on-chip regulators, external regulators switched through general-purpose pins, and a 32 kHz clock. Three master timers give the timing. Each timer is started by one of two hardware enable pins or by a software bit. On every change of that trigger, in either direction, the timer issues eight numbered slot events spaced by a programmable period. All timing is counted from a free-running tick that a prescaler derives from the system clock.

Each output has its own configuration byte. The byte either attaches the output to one of the timers or hands it to a software enable bit. For an attached output, the byte also names the slot at which the output turns on during a rising sequence and the slot at which it acts during a falling sequence. A global idle-mode field decides what that falling action is: switch the output off, keep it on but flag it low-power, or leave it alone. All configuration comes through a simple write-only port.

Top module: `fps_seq_ctrl`

## Requirements
- R1: After reset, every `out_en`, `out_lp` and `tmr_busy` bit is 0. Each timer's trigger source is off, each output is on the software source, and every software bit is 0.
- R2: Timer configuration bytes sit at addresses 0 to 2. Bits [1:0] pick the trigger: 0 is `hw_en_a`, 1 is `hw_en_b`, 2 is the timer's software bit in the global byte, and 3 holds the trigger low, so pin activity has no effect.
- R3: A trigger change is seen in the cycle it appears. Slot 0 fires on the first tick after that cycle, and slot k fires k periods later. An output acting on a slot changes one clock after that slot's tick.
- R4: Timer byte bits [4:2] hold a period code c. The slot spacing is BASE_TICKS·2^c ticks, so each step of the code doubles the spacing.
- R5: Output configuration bytes sit at address 5+i, with the source in bits [1:0] (0 to 2 select a timer, 3 selects software), the up slot in bits [4:2] and the down slot in bits [7:5]. In a rising sequence, the up slot sets `out_en`=1 and `out_lp`=0.
- R6: In a falling sequence with global idle mode 1 (sleep), the down slot clears both `out_en` and `out_lp`.
- R7: In a falling sequence with idle mode 2 (low power), the down slot sets `out_lp`=1 and leaves `out_en` unchanged.
- R8: With idle mode 0 or 3, a falling sequence changes no output.
- R9: For an output on the software source, `out_en` equals bit i of the byte at address 4 from the clock edge that writes it, and `out_lp` is 0.
- R10: A trigger change during a running sequence abandons that sequence. Its remaining slots never fire, and a fresh eight-slot sequence for the new direction starts from slot 0.
- R11: `tmr_busy[t]` rises the clock after a trigger change and falls at the edge where slot 7 is issued.
- R12: The tick repeats every PRESCALE clocks, free-running from reset.
- Global byte (address 4 is the software-enable byte, address 3 the global byte): bits [2:0] are the timer software triggers and bits [5:4] are the idle mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en_a | input | 1 | First hardware trigger pin |
| hw_en_b | input | 1 | Second hardware trigger pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| out_en | output | N_OUT | Per-output enable |
| out_lp | output | N_OUT | Per-output low-power flag |
| tmr_busy | output | 3 | Per-timer sequence-in-progress flag |

## Verification
The hardest case to reach from the ports is a trigger that flips back in the middle of a sequence. The test must show two things: the slots already scheduled for the old direction are silently dropped, and the new sequence restarts from slot 0. The stimulus uses the software trigger of the timer with the doubled period. It computes the cycle that falls inside slot 2 and reverses the trigger there. One output's up slot lies beyond that point, so its staying off proves the drop, and another output's down slot 7 proves the restart timing.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int NUM_TMR  = 3;
  localparam int NUM_SLOT = 8;
  localparam int REG_W    = 8;

  // trigger selection codes
  localparam logic [1:0] TRG_A   = 2'd0;
  localparam logic [1:0] TRG_B   = 2'd1;
  localparam logic [1:0] TRG_SW  = 2'd2;
  localparam logic [1:0] TRG_OFF = 2'd3;

  // idle modes applied on falling sequences
  localparam logic [1:0] IDLE_SLEEP  = 2'd1;
  localparam logic [1:0] IDLE_LOWPWR = 2'd2;

  localparam logic [1:0] SRC_SOFT = 2'd3;

  typedef struct packed {
    logic [2:0] period;
    logic [1:0] src;
  } tmr_cfg_t;

  typedef struct packed {
    logic [2:0] dn_slot;
    logic [2:0] up_slot;
    logic [1:0] src;
  } slv_cfg_t;

  // slot spacing in ticks for a period code
  function automatic int unsigned slot_ticks(input logic [2:0] code,
                                             input int unsigned base);
    return base << code;
  endfunction
endpackage

// File: rtl/fps_tick_gen.sv
module fps_tick_gen #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (PRESCALE > 1) begin : g_gap
      // R12: ticks are isolated single-cycle pulses
      a_r12_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fps_master_tmr.sv
module fps_master_tmr
  import fps_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                hw_a,
  input  logic                hw_b,
  input  logic                sw_trg,
  input  tmr_cfg_t            cfg,
  output logic [NUM_SLOT-1:0] slot_evt,
  output logic                dir,
  output logic                busy
);
  localparam int unsigned MAXT = BASE_TICKS << (NUM_SLOT - 1);
  localparam int unsigned TW   = $clog2(MAXT + 1);

  logic          trg, trg_q, edge_det, fire;
  logic [2:0]    slot_idx;
  logic [TW-1:0] wait_cnt;

  always_comb begin
    case (cfg.src)
      TRG_A:   trg = hw_a;
      TRG_B:   trg = hw_b;
      TRG_SW:  trg = sw_trg;
      default: trg = 1'b0;
    endcase
  end

  assign edge_det = trg ^ trg_q;
  // a new edge outranks a slot due in the same cycle
  assign fire     = busy && tick && (wait_cnt == '0) && !edge_det;
  assign slot_evt = fire ? (NUM_SLOT'(1) << slot_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trg_q    <= 1'b0;
      busy     <= 1'b0;
      dir      <= 1'b0;
      slot_idx <= '0;
      wait_cnt <= '0;
    end else begin
      trg_q <= trg;
      if (edge_det) begin
        busy     <= 1'b1;
        dir      <= trg;
        slot_idx <= '0;
        wait_cnt <= '0;
      end else if (fire) begin
        if (slot_idx == 3'(NUM_SLOT - 1)) begin
          busy <= 1'b0;
        end else begin
          slot_idx <= slot_idx + 1'b1;
          wait_cnt <= TW'(slot_ticks(cfg.period, BASE_TICKS) - 1);
        end
      end else if (busy && tick) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  a_r3_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_evt));
  a_r3_slot_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_evt) |-> tick);
  a_r11_busy_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> busy);
  a_r11_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    slot_evt[NUM_SLOT-1] |=> !busy);
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> (slot_idx == 3'd0));
endmodule

// File: rtl/fps_slave_out.sv
module fps_slave_out
  import fps_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  slv_cfg_t                          cfg,
  input  logic                              sw_bit,
  input  logic [1:0]                        idle_mode,
  input  logic [NUM_TMR-1:0][NUM_SLOT-1:0]  slot_evt_all,
  input  logic [NUM_TMR-1:0]                dir_all,
  output logic                              en_out,
  output logic                              lp_out
);
  logic                on_sw, dir_sel, up_hit, dn_hit, en_q, lp_q;
  logic [NUM_SLOT-1:0] evt;

  assign on_sw = (cfg.src == SRC_SOFT);

  always_comb begin
    evt     = '0;
    dir_sel = 1'b0;
    if (!on_sw) begin
      evt     = slot_evt_all[cfg.src];
      dir_sel = dir_all[cfg.src];
    end
  end

  assign up_hit = dir_sel && evt[cfg.up_slot];
  assign dn_hit = !dir_sel && evt[cfg.dn_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      lp_q <= 1'b0;
    end else if (up_hit) begin
      en_q <= 1'b1;
      lp_q <= 1'b0;
    end else if (dn_hit) begin
      case (idle_mode)
        IDLE_SLEEP: begin
          en_q <= 1'b0;
          lp_q <= 1'b0;
        end
        IDLE_LOWPWR: lp_q <= 1'b1;
        default: ;
      endcase
    end
  end

  // software-sourced outputs bypass the timers entirely
  assign en_out = on_sw ? sw_bit : en_q;
  assign lp_out = on_sw ? 1'b0 : lp_q;

  a_r5_up_on: assert property (@(posedge clk) disable iff (!rst_n)
    up_hit |=> (en_q && !lp_q));
  a_r6_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_hit && idle_mode == IDLE_SLEEP) |=> (!en_q && !lp_q));
  a_r7_lowpwr: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_hit && idle_mode == IDLE_LOWPWR) |=> (lp_q && $stable(en_q)));
  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_hit && (idle_mode == 2'd0 || idle_mode == 2'd3))
      |=> ($stable(en_q) && $stable(lp_q)));
endmodule

// File: rtl/fps_seq_ctrl.sv
module fps_seq_ctrl
  import fps_pkg::*;
#(
  parameter int unsigned N_OUT      = 6,
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned BASE_TICKS = 2,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_en_a,
  input  logic                hw_en_b,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  output logic [N_OUT-1:0]    out_en,
  output logic [N_OUT-1:0]    out_lp,
  output logic [NUM_TMR-1:0]  tmr_busy
);
  localparam int unsigned A_GLOBAL = NUM_TMR;
  localparam int unsigned A_SWEN   = NUM_TMR + 1;
  localparam int unsigned A_SLV0   = NUM_TMR + 2;

  tmr_cfg_t                         tcfg [NUM_TMR];
  slv_cfg_t                         scfg [N_OUT];
  logic [NUM_TMR-1:0]               sw_trg;
  logic [1:0]                       idle_mode;
  logic [N_OUT-1:0]                 sw_en;
  logic                             tick;
  logic [NUM_TMR-1:0][NUM_SLOT-1:0] slot_evt_all;
  logic [NUM_TMR-1:0]               dir_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TMR; t++) tcfg[t] <= '{period: 3'd0, src: TRG_OFF};
      for (int i = 0; i < N_OUT; i++)
        scfg[i] <= '{dn_slot: 3'd0, up_slot: 3'd0, src: SRC_SOFT};
      sw_trg    <= '0;
      idle_mode <= '0;
      sw_en     <= '0;
    end else if (wr_en) begin
      for (int t = 0; t < NUM_TMR; t++)
        if (wr_addr == ADDR_W'(t)) tcfg[t] <= tmr_cfg_t'(wr_data[4:0]);
      if (wr_addr == ADDR_W'(A_GLOBAL)) begin
        sw_trg    <= wr_data[NUM_TMR-1:0];
        idle_mode <= wr_data[5:4];
      end
      if (wr_addr == ADDR_W'(A_SWEN)) sw_en <= N_OUT'(wr_data);
      for (int i = 0; i < N_OUT; i++)
        if (wr_addr == ADDR_W'(A_SLV0 + i)) scfg[i] <= slv_cfg_t'(wr_data);
    end
  end

  fps_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      fps_master_tmr #(.BASE_TICKS(BASE_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .hw_a(hw_en_a), .hw_b(hw_en_b), .sw_trg(sw_trg[t]),
        .cfg(tcfg[t]), .slot_evt(slot_evt_all[t]),
        .dir(dir_all[t]), .busy(tmr_busy[t])
      );
    end
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      fps_slave_out u_out (
        .clk(clk), .rst_n(rst_n), .cfg(scfg[i]), .sw_bit(sw_en[i]),
        .idle_mode(idle_mode), .slot_evt_all(slot_evt_all),
        .dir_all(dir_all), .en_out(out_en[i]), .lp_out(out_lp[i])
      );
    end
  endgenerate
endmodule

// File: tb/sim_fps_seq_ctrl.sv
module sim_fps_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NO   = 6;
  localparam int PRE  = 4;
  localparam int BASE = 2;

  logic clk = 1'b0, rst_n = 1'b0, hw_en_a = 1'b0, hw_en_b = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NO-1:0] out_en, out_lp;
  logic [2:0] tmr_busy;

  fps_seq_ctrl #(.N_OUT(NO), .PRESCALE(PRE), .BASE_TICKS(BASE), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_en_a(hw_en_a), .hw_en_b(hw_en_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_en(out_en), .out_lp(out_lp), .tmr_busy(tmr_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { int cyc; int idx; logic en; logic lp; int req; } exp_t;
  exp_t exp_q[$];
  exp_t item;
  int checks = 0, errors = 0, cyc = 0, c = 0, e = 0;
  logic [2:0] g_sw = '0;
  logic [1:0] g_mode = '0;
  logic [NO-1:0] prv_en, prv_lp;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // slot timing restated: first slot edge is the first multiple of PRE at
  // least two clocks after the trigger cycle; slots then spaced by period
  function automatic int first_edge(input int cc);
    return ((cc + 2 + PRE - 1) / PRE) * PRE;
  endfunction
  function automatic int per_clk(input int code);
    return BASE * (1 << code) * PRE;
  endfunction

  // monitor: every output change must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      prv_en = '0; prv_lp = '0;
    end else begin
      for (int i = 0; i < NO; i++) begin
        if (out_en[i] !== prv_en[i] || out_lp[i] !== prv_lp[i]) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3/R10 out%0d changed at cycle %0d: actual en=%b lp=%b expected no change",
                     i, cyc, out_en[i], out_lp[i]);
          end else begin
            item = exp_q.pop_front();
            if (item.idx != i || item.cyc != cyc || item.en !== out_en[i] || item.lp !== out_lp[i]) begin
              errors++;
              $display("FAIL R%0d actual out%0d cyc=%0d en=%b lp=%b expected out%0d cyc=%0d en=%b lp=%b",
                       item.req, i, cyc, out_en[i], out_lp[i], item.idx, item.cyc, item.en, item.lp);
            end
          end
          prv_en[i] = out_en[i];
          prv_lp[i] = out_lp[i];
        end
      end
    end
  end

  task automatic push(input int cy, input int idx, input logic en, input logic lp, input int req);
    exp_t t;
    t.cyc = cy; t.idx = idx; t.en = en; t.lp = lp; t.req = req;
    exp_q.push_back(t);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_glob();
    wr(4'd3, {2'b00, g_mode, 1'b0, g_sw});
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_en == '0, "R1 out_en", int'(out_en), 0);
    chk(out_lp == '0, "R1 out_lp", int'(out_lp), 0);
    chk(tmr_busy == '0, "R1 tmr_busy", int'(tmr_busy), 0);

    // R2: timer 0 still on source 3, pin activity ignored
    wr(4'd5, {3'd6, 3'd1, 2'd0});
    hw_en_a = 1'b1;
    repeat (12) @(negedge clk);
    chk(tmr_busy[0] == 1'b0, "R2 held-off busy", int'(tmr_busy[0]), 0);
    chk(out_en[0] == 1'b0, "R2 held-off out0", int'(out_en[0]), 0);
    hw_en_a = 1'b0;
    repeat (2) @(negedge clk);

    // configuration
    wr(4'd0, {3'b0, 3'd0, 2'd0});   // timer0: pin a, code 0
    wr(4'd1, {3'b0, 3'd1, 2'd2});   // timer1: software, code 1
    wr(4'd2, {3'b0, 3'd0, 2'd1});   // timer2: pin b, code 0
    wr(4'd6, {3'd2, 3'd3, 2'd0});
    wr(4'd7, {3'd7, 3'd0, 2'd1});
    wr(4'd8, {3'd0, 3'd7, 2'd2});
    wr(4'd9, {3'd0, 3'd0, 2'd3});
    wr(4'd10, {3'd5, 3'd5, 2'd0});
    g_mode = 2'd1; wr_glob();

    // R3 R5 R12: rising sequence on timer0
    hw_en_a = 1'b1; c = cyc; e = first_edge(c);
    push(e + 1*per_clk(0), 0, 1'b1, 1'b0, 3);
    push(e + 3*per_clk(0), 1, 1'b1, 1'b0, 5);
    push(e + 5*per_clk(0), 5, 1'b1, 1'b0, 12);
    @(negedge clk);
    chk(tmr_busy[0] == 1'b1, "R11 busy after edge", int'(tmr_busy[0]), 1);
    wait_cyc(e + 7*per_clk(0) - 1);
    chk(tmr_busy[0] == 1'b1, "R11 busy before slot7", int'(tmr_busy[0]), 1);
    @(negedge clk);
    chk(tmr_busy[0] == 1'b0, "R11 idle after slot7", int'(tmr_busy[0]), 0);
    drain();

    // R6: falling sequence in sleep mode
    hw_en_a = 1'b0; c = cyc; e = first_edge(c);
    push(e + 2*per_clk(0), 1, 1'b0, 1'b0, 6);
    push(e + 5*per_clk(0), 5, 1'b0, 1'b0, 6);
    push(e + 6*per_clk(0), 0, 1'b0, 1'b0, 6);
    drain();

    // R10 R4: abort on timer1 (doubled period)
    wr(4'd6, {3'd1, 3'd5, 2'd1});
    g_sw[1] = 1'b1; wr_glob(); c = cyc; e = first_edge(c);
    push(e, 2, 1'b1, 1'b0, 10);
    wait_cyc(e + 2*per_clk(1) + 3);
    g_sw[1] = 1'b0; wr_glob(); c = cyc; e = first_edge(c);
    chk(tmr_busy[1] == 1'b1, "R10 busy across abort", int'(tmr_busy[1]), 1);
    push(e + 7*per_clk(1), 2, 1'b0, 1'b0, 4);
    drain();
    chk(out_en[1] == 1'b0, "R10 dropped slot stays off", int'(out_en[1]), 0);
    chk(tmr_busy[1] == 1'b0, "R11 idle after restart", int'(tmr_busy[1]), 0);
    wr(4'd6, {3'd2, 3'd3, 2'd0});

    // R7: low-power idle mode
    hw_en_a = 1'b1; c = cyc; e = first_edge(c);
    push(e + 1*per_clk(0), 0, 1'b1, 1'b0, 5);
    push(e + 3*per_clk(0), 1, 1'b1, 1'b0, 5);
    push(e + 5*per_clk(0), 5, 1'b1, 1'b0, 5);
    drain();
    g_mode = 2'd2; wr_glob();
    hw_en_a = 1'b0; c = cyc; e = first_edge(c);
    push(e + 2*per_clk(0), 1, 1'b1, 1'b1, 7);
    push(e + 5*per_clk(0), 5, 1'b1, 1'b1, 7);
    push(e + 6*per_clk(0), 0, 1'b1, 1'b1, 7);
    drain();

    // R8: idle modes 0 and 3 leave outputs alone
    hw_en_a = 1'b1; c = cyc; e = first_edge(c);
    push(e + 1*per_clk(0), 0, 1'b1, 1'b0, 5);
    push(e + 3*per_clk(0), 1, 1'b1, 1'b0, 5);
    push(e + 5*per_clk(0), 5, 1'b1, 1'b0, 5);
    drain();
    g_mode = 2'd0; wr_glob();
    hw_en_a = 1'b0; c = cyc;
    wait_cyc(first_edge(c) + 7*per_clk(0) + 4);
    chk(out_en[0] && out_en[1] && out_en[5], "R8 mode0 en kept", int'(out_en), 35);
    chk(out_lp == '0, "R8 mode0 lp kept", int'(out_lp), 0);
    g_mode = 2'd3; wr_glob();
    hw_en_a = 1'b1; c = cyc;
    wait_cyc(first_edge(c) + 7*per_clk(0) + 4);
    hw_en_a = 1'b0; c = cyc;
    wait_cyc(first_edge(c) + 7*per_clk(0) + 4);
    chk(out_en[0] && out_en[1] && out_en[5], "R8 mode3 en kept", int'(out_en), 35);
    chk(out_lp == '0, "R8 mode3 lp kept", int'(out_lp), 0);

    // R9: software-sourced output follows its bit at the write edge
    push(cyc + 1, 4, 1'b1, 1'b0, 9);
    wr(4'd4, 8'h10);
    chk(out_lp[4] == 1'b0, "R9 soft lp", int'(out_lp[4]), 0);
    push(cyc + 1, 4, 1'b0, 1'b0, 9);
    wr(4'd4, 8'h00);
    drain();

    // R2: timer2 on pin b, slot 7 up and slot 0 down
    g_mode = 2'd1; wr_glob();
    hw_en_b = 1'b1; c = cyc; e = first_edge(c);
    push(e + 7*per_clk(0), 3, 1'b1, 1'b0, 2);
    drain();
    hw_en_b = 1'b0; c = cyc; e = first_edge(c);
    push(e, 3, 1'b0, 1'b0, 6);
    drain();

    chk(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule